// File: doc/BRIEF.md
# Saturating Double-Precision Divider

This block divides one 64-bit binary floating-point value by another over several clock cycles and never produces an infinity, a NaN or a subnormal. Results that cannot be represented are replaced: too large or undefined quotients become the largest finite magnitude, and quotients too small to be normal become a signed zero. The quotient is truncated toward zero. The first discarded quotient bit (guard) and the OR of every lower discarded bit (sticky) are brought out so that trap software can apply any other rounding mode.

A request is issued by pulsing `start` while the unit is idle. The operands and the five exception enables are captured on that edge. The unit stays busy for the mantissa iterations and then reports everything in a single `done` cycle. In that cycle `wr_en` tells the destination whether to accept `quotient`, `trap_req` asks for an exception trap, and `round_trap` asks for the rounding trap. The five status flags collect across operations until reset.

Top module: `sfd_div_unit`

## Requirements
- R1: A `start` sampled while `busy` is low raises `busy` on the next cycle. `done` is a one-cycle pulse that arrives 57 cycles after the start edge, in the first cycle with `busy` low again. A `start` given while `busy` is high is ignored.
- R2: For two normal operands whose quotient is in range, `quotient` equals the exact quotient truncated toward zero: sign = XOR of the signs, biased exponent = ea − eb + 1023, less one when the significand ratio is below 1.
- R3: A NaN or infinite divisor (exponent field all ones) gives a zero whose sign is the XOR of the operand signs, and raises invalid.
- R4: Otherwise, a zero or subnormal divisor, or a NaN or infinite dividend, gives the largest finite magnitude (exponent 0x7FE, fraction all ones), positive when the signs match and negative when they differ. Invalid is raised when either operand is infinite, NaN or subnormal, or when both are zero.
- R5: Divide-by-zero is raised only for a zero divisor with a normal, non-zero dividend. It is never raised together with invalid.
- R6: If the biased exponent of a normal-by-normal quotient exceeds 2046, the result is the largest finite magnitude with the quotient sign, and overflow is raised. When overflow trapping is off, inexact is raised as well.
- R7: If the biased exponent of a normal-by-normal quotient is below 1, the result is a zero with the quotient sign, underflow is raised, and inexact is not raised.
- R8: When a raised exception of the kinds invalid, divide-by-zero, overflow or underflow has its enable set, `trap_req` pulses with `done`, `wr_en` stays low, and inexact is not raised. Otherwise `wr_en` pulses with `done`.
- R9: Inexact is raised when guard or sticky is set on an in-range quotient and no trap is taken. When inexact trapping is enabled, `round_trap` pulses together with `wr_en`.
- R10: `guard_bit` is the first quotient bit below the kept 53-bit significand. `sticky_bit` is the OR of all lower quotient bits and the final remainder. Both read 0 after any operation that raises overflow, underflow, divide-by-zero or invalid.
- R11: Each status flag, once set, stays set across later operations until reset, and all flags clear on reset.
- R12: A written quotient never has an all-ones exponent field, and has a zero fraction whenever its exponent field is zero.
- R13: A zero or subnormal dividend with a normal divisor gives a zero with the quotient sign. A subnormal dividend also raises invalid, and a zero one raises nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a divide; honoured only while idle |
| dividend | input | 64 | Numerator, binary64 |
| divisor | input | 64 | Denominator, binary64 |
| en_invalid | input | 1 | Trap enable for invalid |
| en_divzero | input | 1 | Trap enable for divide-by-zero |
| en_overflow | input | 1 | Trap enable for overflow |
| en_underflow | input | 1 | Trap enable for underflow |
| en_inexact | input | 1 | Rounding-trap enable for inexact |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 64 | Truncated, saturated result, held until the next completion |
| wr_en | output | 1 | Destination write strobe, with done |
| flg_invalid | output | 1 | Sticky invalid flag |
| flg_divzero | output | 1 | Sticky divide-by-zero flag |
| flg_overflow | output | 1 | Sticky overflow flag |
| flg_underflow | output | 1 | Sticky underflow flag |
| flg_inexact | output | 1 | Sticky inexact flag |
| guard_bit | output | 1 | First discarded quotient bit |
| sticky_bit | output | 1 | OR of lower discarded bits and remainder |
| trap_req | output | 1 | Exception trap request, with done |
| round_trap | output | 1 | Rounding trap request, with done |

## Verification
Exact ratios such as 6/3 and 3/2 show that the divider leaves guard and sticky clear. Repeating ratios such as 1/3 and 1/1.5 separate a wrong guard bit from a wrong sticky bit. Ratios below one, such as 1/1.5, check the exponent decrement and the shifted significand window. Random normal operands with mixed signs are compared against a wide-integer reference, which exercises every bit of the quotient. Operand pairs taken from each special-case row, together with exponent pairs placed just inside and just outside the range, show the priority between the saturate and flush rules and the effect of each trap enable on the write and flag outputs.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
   typedef enum logic [1:0] {
      CLS_ZERO = 2'd0,
      CLS_NORM = 2'd1,
      CLS_SUB  = 2'd2,
      CLS_SPEC = 2'd3
   } opclass_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } dstate_e;

   typedef struct packed {
      logic inv;
      logic dbz;
      logic ovf;
      logic unf;
      logic inx;
   } xflags_t;
endpackage

// File: rtl/sfd_classify.sv
module sfd_classify
   import sfd_pkg::*;
#(
   parameter int EXP_W = 11,
   parameter int MAN_W = 52,
   localparam int W = 1 + EXP_W + MAN_W
) (
   input  logic [W-1:0]     op,
   output opclass_e         cls,
   output logic             sgn,
   output logic [EXP_W-1:0] expo
);
   logic [MAN_W-1:0] frac;

   assign sgn  = op[W-1];
   assign expo = op[W-2 -: EXP_W];
   assign frac = op[MAN_W-1:0];

   always_comb begin
      if (&expo)
         cls = CLS_SPEC;
      else if (expo == '0)
         cls = (frac == '0) ? CLS_ZERO : CLS_SUB;
      else
         cls = CLS_NORM;
   end
endmodule

// File: rtl/sfd_mant_div.sv
module sfd_mant_div #(
   parameter int SIG_W = 53,
   parameter int QBITS = 55
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic [SIG_W-1:0] num,
   input  logic [SIG_W-1:0] den,
   output logic [QBITS-1:0] qbits,
   output logic             rem_nz
);
   logic [SIG_W:0]   rem_q;
   logic [SIG_W-1:0] den_q;
   logic [SIG_W:0]   diff;
   logic             ge;

   assign ge     = rem_q >= {1'b0, den_q};
   assign diff   = rem_q - {1'b0, den_q};
   assign rem_nz = |rem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         den_q <= '0;
         qbits <= '0;
      end else if (load) begin
         rem_q <= {1'b0, num};
         den_q <= den;
         qbits <= '0;
      end else if (step) begin
         rem_q <= ge ? {diff[SIG_W-1:0], 1'b0} : {rem_q[SIG_W-1:0], 1'b0};
         qbits <= {qbits[QBITS-2:0], ge};
      end
   end
endmodule

// File: rtl/sfd_pack.sv
module sfd_pack
   import sfd_pkg::*;
#(
   parameter int EXP_W = 11,
   parameter int MAN_W = 52,
   localparam int W     = 1 + EXP_W + MAN_W,
   localparam int QBITS = MAN_W + 3
) (
   input  opclass_e         cls_a,
   input  opclass_e         cls_b,
   input  logic             sgn_a,
   input  logic             sgn_b,
   input  logic [EXP_W-1:0] exp_a,
   input  logic [EXP_W-1:0] exp_b,
   input  logic [QBITS-1:0] qbits,
   input  logic             rem_nz,
   input  xflags_t          en,
   output logic [W-1:0]     result,
   output xflags_t          flags,
   output logic             guard,
   output logic             sticky,
   output logic             trap,
   output logic             rtrap
);
   localparam int XW   = EXP_W + 2;
   localparam int BIAS = (1 << (EXP_W - 1)) - 1;
   localparam int EMAX = (1 << EXP_W) - 2;

   logic                    sr, nn, inv, dbz, ovf, unf, g_raw, s_raw, inrange;
   logic signed [XW-1:0]    ex;
   logic [MAN_W-1:0]        frac;
   logic [W-1:0]            maxf, zero;

   assign sr   = sgn_a ^ sgn_b;
   assign maxf = {sr, {(EXP_W-1){1'b1}}, 1'b0, {MAN_W{1'b1}}};
   assign zero = {sr, {(W-1){1'b0}}};
   assign nn   = (cls_a == CLS_NORM) && (cls_b == CLS_NORM);

   assign inv = (cls_a == CLS_SPEC) || (cls_a == CLS_SUB) ||
                (cls_b == CLS_SPEC) || (cls_b == CLS_SUB) ||
                ((cls_a == CLS_ZERO) && (cls_b == CLS_ZERO));
   assign dbz = !inv && (cls_b == CLS_ZERO) && (cls_a == CLS_NORM);

   assign ex = $signed({2'b00, exp_a}) - $signed({2'b00, exp_b})
             + XW'(BIAS) - (qbits[QBITS-1] ? XW'(0) : XW'(1));

   assign ovf     = nn && (ex > $signed(XW'(EMAX)));
   assign unf     = nn && (ex < $signed(XW'(1)));
   assign inrange = nn && !ovf && !unf;

   always_comb begin
      if (qbits[QBITS-1]) begin
         frac  = qbits[QBITS-2 -: MAN_W];
         g_raw = qbits[1];
         s_raw = qbits[0] | rem_nz;
      end else begin
         frac  = qbits[QBITS-3 -: MAN_W];
         g_raw = qbits[0];
         s_raw = rem_nz;
      end
   end

   always_comb begin
      if (cls_b == CLS_SPEC)
         result = zero;
      else if ((cls_b == CLS_ZERO) || (cls_b == CLS_SUB) || (cls_a == CLS_SPEC))
         result = maxf;
      else if ((cls_a == CLS_ZERO) || (cls_a == CLS_SUB))
         result = zero;
      else if (ovf)
         result = maxf;
      else if (unf)
         result = zero;
      else
         result = {sr, ex[EXP_W-1:0], frac};
   end

   assign guard  = inrange & g_raw;
   assign sticky = inrange & s_raw;

   assign trap  = (inv & en.inv) | (dbz & en.dbz) | (ovf & en.ovf) | (unf & en.unf);

   assign flags.inv = inv;
   assign flags.dbz = dbz;
   assign flags.ovf = ovf;
   assign flags.unf = unf;
   assign flags.inx = !trap && ((inrange && (g_raw || s_raw)) || (ovf && !en.ovf));
   assign rtrap     = flags.inx & en.inx;
endmodule

// File: rtl/sfd_div_unit.sv
module sfd_div_unit
   import sfd_pkg::*;
#(
   parameter int EXP_W = 11,
   parameter int MAN_W = 52,
   localparam int W = 1 + EXP_W + MAN_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] dividend,
   input  logic [W-1:0] divisor,
   input  logic         en_invalid,
   input  logic         en_divzero,
   input  logic         en_overflow,
   input  logic         en_underflow,
   input  logic         en_inexact,
   output logic         busy,
   output logic         done,
   output logic [W-1:0] quotient,
   output logic         wr_en,
   output logic         flg_invalid,
   output logic         flg_divzero,
   output logic         flg_overflow,
   output logic         flg_underflow,
   output logic         flg_inexact,
   output logic         guard_bit,
   output logic         sticky_bit,
   output logic         trap_req,
   output logic         round_trap
);
   localparam int SIG_W = MAN_W + 1;
   localparam int QBITS = MAN_W + 3;
   localparam int CW    = $clog2(QBITS);

   if (EXP_W < 3 || MAN_W < 4) begin : g_bad_cfg
      $error("sfd_div_unit: exponent or fraction width too small");
   end

   dstate_e          st_q;
   logic [CW-1:0]    cnt_q;
   logic [W-1:0]     opr_q [2];
   xflags_t          en_q, flg_q, fl_now;
   opclass_e         cls_v [2];
   logic             sgn_v [2];
   logic [EXP_W-1:0] exp_v [2];
   logic [QBITS-1:0] qbits;
   logic             rem_nz, launch, pk_g, pk_s, pk_trap, pk_rtrap;
   logic [W-1:0]     pk_res;
   xflags_t          en_in;

   assign launch = (st_q == ST_IDLE) && start;
   assign busy   = (st_q != ST_IDLE);
   assign en_in  = '{inv: en_invalid, dbz: en_divzero, ovf: en_overflow,
                     unf: en_underflow, inx: en_inexact};

   for (genvar k = 0; k < 2; k++) begin : g_cls
      sfd_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) cls_i (
         .op  (opr_q[k]),
         .cls (cls_v[k]),
         .sgn (sgn_v[k]),
         .expo(exp_v[k])
      );
   end

   sfd_mant_div #(.SIG_W(SIG_W), .QBITS(QBITS)) mdiv_i (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (launch),
      .step  (st_q == ST_RUN),
      .num   ({1'b1, dividend[MAN_W-1:0]}),
      .den   ({1'b1, divisor[MAN_W-1:0]}),
      .qbits (qbits),
      .rem_nz(rem_nz)
   );

   sfd_pack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) pack_i (
      .cls_a (cls_v[0]),
      .cls_b (cls_v[1]),
      .sgn_a (sgn_v[0]),
      .sgn_b (sgn_v[1]),
      .exp_a (exp_v[0]),
      .exp_b (exp_v[1]),
      .qbits (qbits),
      .rem_nz(rem_nz),
      .en    (en_q),
      .result(pk_res),
      .flags (fl_now),
      .guard (pk_g),
      .sticky(pk_s),
      .trap  (pk_trap),
      .rtrap (pk_rtrap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         cnt_q      <= '0;
         opr_q[0]   <= '0;
         opr_q[1]   <= '0;
         en_q       <= '0;
         flg_q      <= '0;
         quotient   <= '0;
         guard_bit  <= 1'b0;
         sticky_bit <= 1'b0;
         done       <= 1'b0;
         wr_en      <= 1'b0;
         trap_req   <= 1'b0;
         round_trap <= 1'b0;
      end else begin
         done       <= 1'b0;
         wr_en      <= 1'b0;
         trap_req   <= 1'b0;
         round_trap <= 1'b0;
         unique case (st_q)
            ST_IDLE: if (start) begin
               opr_q[0] <= dividend;
               opr_q[1] <= divisor;
               en_q     <= en_in;
               cnt_q    <= '0;
               st_q     <= ST_RUN;
            end
            ST_RUN: begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == CW'(QBITS - 1))
                  st_q <= ST_FIN;
            end
            ST_FIN: begin
               quotient   <= pk_res;
               guard_bit  <= pk_g;
               sticky_bit <= pk_s;
               flg_q      <= flg_q | fl_now;
               done       <= 1'b1;
               wr_en      <= !pk_trap;
               trap_req   <= pk_trap;
               round_trap <= pk_rtrap;
               st_q       <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign flg_invalid   = flg_q.inv;
   assign flg_divzero   = flg_q.dbz;
   assign flg_overflow  = flg_q.ovf;
   assign flg_underflow = flg_q.unf;
   assign flg_inexact   = flg_q.inx;
endmodule

// File: rtl/sfd_div_chk.sv
module sfd_div_chk #(
   parameter int EXP_W = 11,
   parameter int MAN_W = 52,
   localparam int W = 1 + EXP_W + MAN_W
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic         busy,
   input logic         done,
   input logic         wr_en,
   input logic         trap_req,
   input logic         round_trap,
   input logic [W-1:0] quotient,
   input logic         flg_invalid
);
   // R1
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   // R1
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R1
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R8
   trap_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> (done && !wr_en));

   // R8
   write_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> done);

   // R9
   rtrap_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      round_trap |-> wr_en);

   // R12
   no_infnan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !(&quotient[W-2 -: EXP_W]));

   // R12
   no_subnormal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (quotient[W-2 -: EXP_W] == '0)) |-> (quotient[MAN_W-1:0] == '0));

   // R11
   inv_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flg_invalid |=> flg_invalid);
endmodule

bind sfd_div_unit sfd_div_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) chk_i (.*);

// File: tb/sfd_div_unit_tb.sv
module sfd_div_unit_tb_top;
   localparam logic [63:0] ONE  = 64'h3FF0000000000000;
   localparam logic [63:0] TWO  = 64'h4000000000000000;
   localparam logic [63:0] THR  = 64'h4008000000000000;
   localparam logic [63:0] SIX  = 64'h4018000000000000;
   localparam logic [63:0] ONEH = 64'h3FF8000000000000;
   localparam logic [63:0] NTWO = 64'hC000000000000000;
   localparam logic [63:0] NTHR = 64'hC008000000000000;
   localparam logic [63:0] PINF = 64'h7FF0000000000000;
   localparam logic [63:0] QNAN = 64'h7FF8000000000000;
   localparam logic [63:0] PZER = 64'h0000000000000000;
   localparam logic [63:0] NZER = 64'h8000000000000000;
   localparam logic [63:0] SUBN = 64'h0000000000000001;
   localparam logic [63:0] PMAX = 64'h7FEFFFFFFFFFFFFF;
   localparam logic [63:0] NMAX = 64'hFFEFFFFFFFFFFFFF;
   localparam logic [63:0] BIG  = 64'h7FE0000000000000;
   localparam logic [63:0] HALF = 64'h3FE0000000000000;
   localparam logic [63:0] TINY = 64'h0010000000000000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [63:0] dividend = '0, divisor = '0;
   logic [4:0]  en = '0;   // {inv, dbz, ovf, unf, inx}
   logic busy, done, wr_en, trap_req, round_trap, guard_bit, sticky_bit;
   logic flg_invalid, flg_divzero, flg_overflow, flg_underflow, flg_inexact;
   logic [63:0] quotient;

   int n_chk = 0;
   int n_bad = 0;
   logic finished = 1'b0;

   logic [63:0] r_q;
   logic r_wr, r_tr, r_rt, r_g, r_s;
   logic [4:0] r_fl;
   int r_lat;

   always #2.5 clk = ~clk;

   sfd_div_unit dut_i (
      .clk(clk), .rst_n(rst_n), .start(start),
      .dividend(dividend), .divisor(divisor),
      .en_invalid(en[4]), .en_divzero(en[3]), .en_overflow(en[2]),
      .en_underflow(en[1]), .en_inexact(en[0]),
      .busy(busy), .done(done), .quotient(quotient), .wr_en(wr_en),
      .flg_invalid(flg_invalid), .flg_divzero(flg_divzero),
      .flg_overflow(flg_overflow), .flg_underflow(flg_underflow),
      .flg_inexact(flg_inexact), .guard_bit(guard_bit), .sticky_bit(sticky_bit),
      .trap_req(trap_req), .round_trap(round_trap)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      start = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Reference: wide-integer quotient, truncated
   task automatic ref_div(input logic [63:0] a, input logic [63:0] b,
                          output logic [63:0] q, output logic g, output logic s,
                          output logic ovf, output logic unf);
      logic [127:0] n, d, qq, rr;
      logic [51:0] fr;
      int e;
      n  = {75'd0, 1'b1, a[51:0]} << 54;
      d  = {75'd0, 1'b1, b[51:0]};
      qq = n / d;
      rr = n % d;
      e  = int'(a[62:52]) - int'(b[62:52]) + 1023;
      if (qq[54]) begin
         fr = qq[53:2]; g = qq[1]; s = qq[0] | (rr != 0);
      end else begin
         e = e - 1; fr = qq[52:1]; g = qq[0]; s = (rr != 0);
      end
      ovf = (e > 2046);
      unf = (e < 1);
      if (ovf)      q = (a[63] ^ b[63]) ? NMAX : PMAX;
      else if (unf) q = {a[63] ^ b[63], 63'd0};
      else          q = {a[63] ^ b[63], e[10:0], fr};
      if (ovf || unf) begin g = 1'b0; s = 1'b0; end
   endtask

   task automatic run_op(input logic [63:0] a, input logic [63:0] b, input logic [4:0] e);
      int k;
      @(negedge clk);
      dividend = a; divisor = b; en = e; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      k = 1;
      while (!done && k < 200) begin
         @(negedge clk);
         k++;
      end
      r_lat = k;
      r_q = quotient; r_wr = wr_en; r_tr = trap_req; r_rt = round_trap;
      r_g = guard_bit; r_s = sticky_bit;
      r_fl = {flg_invalid, flg_divzero, flg_overflow, flg_underflow, flg_inexact};
   endtask

   task automatic expect_op(input string tag, input logic [63:0] q, input logic wr,
                            input logic tr, input logic rt, input logic [4:0] fl,
                            input logic g, input logic s);
      chk({tag, " quotient"}, r_q, q);
      chk({tag, " wr_en"}, 64'(r_wr), 64'(wr));
      chk({tag, " trap_req"}, 64'(r_tr), 64'(tr));
      chk({tag, " round_trap"}, 64'(r_rt), 64'(rt));
      chk({tag, " flags"}, 64'(r_fl), 64'(fl));
      chk({tag, " guard"}, 64'(r_g), 64'(g));
      chk({tag, " sticky"}, 64'(r_s), 64'(s));
   endtask

   task automatic normal_case(input string tag, input logic [63:0] a, input logic [63:0] b);
      logic [63:0] q;
      logic g, s, ov, un;
      do_reset();
      ref_div(a, b, q, g, s, ov, un);
      run_op(a, b, 5'b00000);
      expect_op(tag, q, 1'b1, 1'b0, 1'b0, {2'b00, ov, un, ov | ((g | s) & !un)}, g, s);
   endtask

   task automatic t_reset();
      do_reset();
      @(negedge clk);
      chk("R11 reset flags", {flg_invalid, flg_divzero, flg_overflow, flg_underflow, flg_inexact}, 0);
      chk("R1 reset busy", 64'(busy), 0);
      chk("R1 reset done", 64'(done), 0);
      chk("R1 reset quotient", quotient, 0);
   endtask

   task automatic t_handshake();
      do_reset();
      @(negedge clk);
      dividend = SIX; divisor = THR; en = '0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R1 busy after start", 64'(busy), 1);
      repeat (5) @(negedge clk);
      dividend = ONE; divisor = THR; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
      chk("R1 start while busy ignored", quotient, TWO);
      chk("R1 busy low at done", 64'(busy), 0);
      @(negedge clk);
      chk("R1 done one cycle", 64'(done), 0);
      begin
         int pulses = 0;
         for (int i = 0; i < 70; i++) begin
            @(negedge clk);
            if (done) pulses++;
         end
         chk("R1 no second completion", 64'(pulses), 0);
      end
      do_reset();
      run_op(SIX, THR, '0);
      chk("R1 latency", 64'(r_lat), 57);
   endtask

   task automatic t_normals();
      normal_case("R2 6/3", SIX, THR);
      normal_case("R2 3/2", THR, TWO);
      normal_case("R2 R9 R10 1/3", ONE, THR);
      normal_case("R2 R10 1/1.5", ONE, ONEH);
      normal_case("R2 -3/2", NTHR, TWO);
      normal_case("R2 2/-3", TWO, NTHR);
      normal_case("R2 pi/e", 64'h400921FB54442D18, 64'h4005BF0A8B145769);
      normal_case("R6 top exponent kept", BIG, ONE);
      normal_case("R7 bottom exponent kept", TINY, ONE);
      for (int i = 0; i < 24; i++) begin
         logic [63:0] a, b;
         a = {1'($urandom), 11'(900 + $urandom_range(0, 250)), $urandom(), 20'($urandom)};
         b = {1'($urandom), 11'(900 + $urandom_range(0, 250)), $urandom(), 20'($urandom)};
         normal_case($sformatf("R2 R10 random %0d", i), a, b);
      end
   endtask

   task automatic t_divisor_special();
      do_reset(); run_op(ONE, PINF, '0);
      expect_op("R3 1/inf", PZER, 1, 0, 0, 5'b10000, 0, 0);
      do_reset(); run_op(NTHR, QNAN, '0);
      expect_op("R3 -3/nan", NZER, 1, 0, 0, 5'b10000, 0, 0);
      do_reset(); run_op(QNAN, PINF, '0);
      expect_op("R3 nan/inf", PZER, 1, 0, 0, 5'b10000, 0, 0);
   endtask

   task automatic t_saturate();
      do_reset(); run_op(PINF, TWO, '0);
      expect_op("R4 inf/2", PMAX, 1, 0, 0, 5'b10000, 0, 0);
      do_reset(); run_op(QNAN, NTWO, '0);
      expect_op("R4 nan/-2", NMAX, 1, 0, 0, 5'b10000, 0, 0);
      do_reset(); run_op(TWO, SUBN, '0);
      expect_op("R4 2/subnormal", PMAX, 1, 0, 0, 5'b10000, 0, 0);
      do_reset(); run_op(PZER, NZER, '0);
      expect_op("R4 0/-0", NMAX, 1, 0, 0, 5'b10000, 0, 0);
   endtask

   task automatic t_divzero();
      do_reset(); run_op(TWO, PZER, '0);
      expect_op("R5 2/0", PMAX, 1, 0, 0, 5'b01000, 0, 0);
      do_reset(); run_op(NTWO, PZER, '0);
      expect_op("R5 -2/0", NMAX, 1, 0, 0, 5'b01000, 0, 0);
      do_reset(); run_op(TWO, PZER, 5'b01000);
      expect_op("R5 R8 2/0 trapped", PMAX, 0, 1, 0, 5'b01000, 0, 0);
   endtask

   task automatic t_range();
      do_reset(); run_op(BIG, HALF, '0);
      expect_op("R6 overflow", PMAX, 1, 0, 0, 5'b00101, 0, 0);
      do_reset(); run_op(BIG, {1'b1, HALF[62:0]}, '0);
      expect_op("R6 negative overflow", NMAX, 1, 0, 0, 5'b00101, 0, 0);
      do_reset(); run_op(BIG, HALF, 5'b00100);
      expect_op("R6 R8 overflow trapped", PMAX, 0, 1, 0, 5'b00100, 0, 0);
      do_reset(); run_op(TINY, TWO, '0);
      expect_op("R7 underflow", PZER, 1, 0, 0, 5'b00010, 0, 0);
      do_reset(); run_op(TINY, NTWO, '0);
      expect_op("R7 negative underflow", NZER, 1, 0, 0, 5'b00010, 0, 0);
      do_reset(); run_op(TINY, TWO, 5'b00010);
      expect_op("R7 R8 underflow trapped", PZER, 0, 1, 0, 5'b00010, 0, 0);
   endtask

   task automatic t_traps();
      logic [63:0] q;
      logic g, s, ov, un;
      do_reset(); run_op(PINF, TWO, 5'b10000);
      expect_op("R8 invalid trapped", PMAX, 0, 1, 0, 5'b10000, 0, 0);
      do_reset(); run_op(PINF, TWO, 5'b01111);
      expect_op("R8 other enables no trap", PMAX, 1, 0, 0, 5'b10000, 0, 0);
      ref_div(ONE, THR, q, g, s, ov, un);
      do_reset(); run_op(ONE, THR, 5'b00001);
      expect_op("R9 inexact round trap", q, 1, 0, 1, 5'b00001, g, s);
      do_reset(); run_op(SIX, THR, 5'b00001);
      expect_op("R9 exact no round trap", TWO, 1, 0, 0, 5'b00000, 0, 0);
   endtask

   task automatic t_zero_dividend();
      do_reset(); run_op(PZER, NTWO, '0);
      expect_op("R13 0/-2", NZER, 1, 0, 0, 5'b00000, 0, 0);
      do_reset(); run_op({1'b1, SUBN[62:0]}, TWO, '0);
      expect_op("R13 -subnormal/2", NZER, 1, 0, 0, 5'b10000, 0, 0);
   endtask

   task automatic t_sticky_flags();
      do_reset();
      run_op(TWO, PZER, '0);
      run_op(ONE, THR, '0);
      chk("R11 divzero kept", 64'(r_fl), 64'(5'b01001));
      run_op(SIX, THR, '0);
      chk("R11 flags kept after clean op", 64'(r_fl), 64'(5'b01001));
      chk("R10 exact clears guard", 64'({r_g, r_s}), 0);
   endtask

   initial begin
      t_reset();
      t_handshake();
      t_normals();
      t_divisor_special();
      t_saturate();
      t_divzero();
      t_range();
      t_traps();
      t_zero_dividend();
      t_sticky_flags();
      finished = 1'b1;
      report();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         report();
         $finish;
      end
   end
endmodule